// File: doc/BRIEF.md
# Neighbour-Mapped Pixel Memory Arbiter

This block connects a small SIMD grid of processing elements to the local data memories the elements own. Each element holds one square tile of an image in its memory. Every element issues the same access in the same cycle: a pixel position inside its own tile plus a signed offset. The arbiter folds the offset into a tile-local address and picks which memory serves each element. The choice is the element's own memory or one of its eight immediate neighbours. The same relative access is made everywhere, so every memory is read at one shared address and no two elements contend. An element can therefore read a pixel stored next door with no special instruction.

Elements on the grid edge have no neighbour on one or more sides. For those reads a programmable boundary byte takes the place of the missing data. An initialization strobe loads that byte.

In binary mode each tile row is packed as one byte, eight pixels at one bit each. The arbiter then returns an 8-bit window that starts at any bit position. The window is merged from two horizontally adjacent bytes, which may belong to two different elements or come from the boundary byte. Reads take one cycle.

Top module: `nbr_pixel_arbiter`

## Requirements
- R1: After reset, pixValid is low and the boundary byte is 0x00, so an off-grid read issued before any boundary write returns 0x00.
- R2: memRdEn equals reqValid in the same cycle, and pixValid is high in exactly the cycle after a cycle with reqValid high.
- R3: In grey mode (reqBinary low), with tx = pixX + offX and ty = pixY + offY taken as signed integers, memRdAddr equals (planeBase + 8*(ty mod 8) + (tx mod 8)) mod 2^ADDR_W.
- R4: In grey mode the byte returned to element (col, row) is the byte read from the memory of element (col + floor(tx/8), row + floor(ty/8)). Element k's data sits at bits 8k+7..8k of memRdData and pixData, with k = row*GRID_COLS + col.
- R5: When the source element of a grey read lies outside the grid, the element receives the boundary byte instead.
- R6: In binary mode memRdAddr equals (planeBase + (ty mod 8)) mod 2^ADDR_W, and pixX is ignored.
- R7: In binary mode bit i (i = 0..7) of an element's result is the pixel at tile-relative column offX + i of row ty. Columns below 0 come from the west neighbour's byte and columns 8 and above come from the east neighbour's byte. Each is taken at bit position (offX + i) mod 8, with bit 0 the leftmost pixel.
- R8: In binary mode any result bit whose source element is off the grid takes the boundary byte's bit at the same position (offX + i) mod 8.
- R9: A cycle with bndWrite high loads bndValue into the boundary byte, and that value is used by results presented from the next cycle on. bndValue has no effect while bndWrite is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Shared read request for all elements |
| reqBinary | input | 1 | 1 selects packed binary window mode, 0 selects grey byte mode |
| planeBase | input | ADDR_W | Base address of the image plane in every local memory |
| pixX | input | 3 | Pixel column inside the tile (grey mode only) |
| pixY | input | 3 | Pixel row inside the tile |
| offX | input | 4 | Signed column offset, -8..7 |
| offY | input | 4 | Signed row offset, -8..7 |
| bndWrite | input | 1 | Load strobe for the boundary byte |
| bndValue | input | 8 | Boundary byte value |
| memRdEn | output | 1 | Read enable to every local memory |
| memRdAddr | output | ADDR_W | Shared read address to every local memory |
| memRdData | input | 8*GRID_COLS*GRID_ROWS | Read data of all memories, one cycle after memRdEn |
| pixValid | output | 1 | Result valid |
| pixData | output | 8*GRID_COLS*GRID_ROWS | One result byte per element |

## Verification
The bench builds the arbiter as a 3x3 grid with a 9-bit address. In that grid one element is a corner, one sits on an edge and one has all eight neighbours, so every neighbour direction and every kind of off-grid substitution shows up in each request. The memory contents are a closed-form function of element index and address. With that, the bench sweeps every pixel position and every offset from -8 to 7 on both axes in grey mode, and every row and offset in binary mode. Those sweeps cover every tile-wrap, every byte-straddling shift and the address wrap at the top of memory.

// File: rtl/nbr_arb_pkg.sv
`timescale 1ns/1ps
package nbr_arb_pkg;
  // tile side in pixels; binary mode packs one tile row into one byte,
  // so the tile side and the pixel byte width must agree
  localparam int TileSide = 8;
  localparam int TileBits = $clog2(TileSide);
  localparam int PixBits  = 8;
  localparam int OffBits  = TileBits + 1;

  typedef enum logic [1:0] {
    DIR_SELF = 2'd0,
    DIR_LOW  = 2'd1,
    DIR_HIGH = 2'd2
  } nbrDir_e;

  typedef struct packed {
    logic                rdValid;
    logic                binMode;
    nbrDir_e             colDir;
    nbrDir_e             rowDir;
    logic [TileBits-1:0] bitShift;
    logic                bndLoad;
    logic [PixBits-1:0]  bndValue;
  } nbrStrobe_t;

  function automatic int dirStep(nbrDir_e d);
    case (d)
      DIR_LOW:  return -1;
      DIR_HIGH: return 1;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/nbr_arb_ctrl.sv
`timescale 1ns/1ps
module nbr_arb_ctrl
  import nbr_arb_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqBinary,
  input  logic [ADDR_W-1:0]   planeBase,
  input  logic [TileBits-1:0] pixX,
  input  logic [TileBits-1:0] pixY,
  input  logic [OffBits-1:0]  offX,
  input  logic [OffBits-1:0]  offY,
  input  logic                bndWrite,
  input  logic [PixBits-1:0]  bndValue,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memRdAddr,
  output nbrStrobe_t          strobe
);
  localparam int SumBits = TileBits + 2;

  logic signed [SumBits-1:0] tgtX, tgtY;
  logic [TileBits-1:0]       locX, locY;
  nbrDir_e                   colDirD, rowDirD;
  logic [ADDR_W-1:0]         grayAddr, binAddr;

  logic                rdValidQ, binModeQ;
  nbrDir_e             colDirQ, rowDirQ;
  logic [TileBits-1:0] bitShiftQ;

  function automatic nbrDir_e wrapDir(logic signed [SumBits-1:0] v);
    if (v < 0) return DIR_LOW;
    if (v >= SumBits'(TileSide)) return DIR_HIGH;
    return DIR_SELF;
  endfunction

  always_comb begin
    tgtX = $signed({2'b00, pixX}) + $signed({offX[OffBits-1], offX});
    tgtY = $signed({2'b00, pixY}) + $signed({offY[OffBits-1], offY});
    locX = tgtX[TileBits-1:0];
    locY = tgtY[TileBits-1:0];
    rowDirD = wrapDir(tgtY);
    if (reqBinary) colDirD = offX[OffBits-1] ? DIR_LOW : DIR_SELF;
    else           colDirD = wrapDir(tgtX);
    grayAddr = planeBase + ADDR_W'({locY, locX});
    binAddr  = planeBase + ADDR_W'(locY);
  end

  assign memRdEn   = reqValid;
  assign memRdAddr = reqBinary ? binAddr : grayAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ  <= 1'b0;
      binModeQ  <= 1'b0;
      colDirQ   <= DIR_SELF;
      rowDirQ   <= DIR_SELF;
      bitShiftQ <= '0;
    end else begin
      rdValidQ <= reqValid;
      if (reqValid) begin
        binModeQ  <= reqBinary;
        colDirQ   <= colDirD;
        rowDirQ   <= rowDirD;
        bitShiftQ <= reqBinary ? offX[TileBits-1:0] : '0;
      end
    end
  end

  always_comb begin
    strobe.rdValid  = rdValidQ;
    strobe.binMode  = binModeQ;
    strobe.colDir   = colDirQ;
    strobe.rowDir   = rowDirQ;
    strobe.bitShift = bitShiftQ;
    strobe.bndLoad  = bndWrite;
    strobe.bndValue = bndValue;
  end
endmodule

// File: rtl/nbr_arb_datapath.sv
`timescale 1ns/1ps
module nbr_arb_datapath
  import nbr_arb_pkg::*;
#(
  parameter int GRID_COLS = 8,
  parameter int GRID_ROWS = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  nbrStrobe_t                            strobe,
  input  logic [PixBits*GRID_COLS*GRID_ROWS-1:0] memRdData,
  output logic [PixBits*GRID_COLS*GRID_ROWS-1:0] pixData
);
  localparam int NumElem = GRID_COLS * GRID_ROWS;

  logic [PixBits-1:0] bndQ;

  always_ff @(posedge clk) begin
    if (!rstN)              bndQ <= '0;
    else if (strobe.bndLoad) bndQ <= strobe.bndValue;
  end

  function automatic logic onGrid(int c, int r);
    return (c >= 0) && (c < GRID_COLS) && (r >= 0) && (r < GRID_ROWS);
  endfunction

  for (genvar r = 0; r < GRID_ROWS; r++) begin : g_row
    for (genvar c = 0; c < GRID_COLS; c++) begin : g_col
      localparam int ElemIdx = r * GRID_COLS + c;
      int                   srcCol, srcRow, idxA, idxB;
      logic                 hitA, hitB;
      logic [PixBits-1:0]   byteA, byteB;
      logic [2*PixBits-1:0] pairWord;

      always_comb begin
        srcCol = c + dirStep(strobe.colDir);
        srcRow = r + dirStep(strobe.rowDir);
        hitA   = onGrid(srcCol, srcRow);
        hitB   = onGrid(srcCol + 1, srcRow);
        idxA   = hitA ? srcRow * GRID_COLS + srcCol : 0;
        idxB   = hitB ? srcRow * GRID_COLS + srcCol + 1 : 0;
        byteA  = hitA ? memRdData[idxA*PixBits +: PixBits] : bndQ;
        byteB  = hitB ? memRdData[idxB*PixBits +: PixBits] : bndQ;
        pairWord = {byteB, byteA} >> strobe.bitShift;
      end

      assign pixData[ElemIdx*PixBits +: PixBits] =
        strobe.binMode ? pairWord[PixBits-1:0] : byteA;
    end
  end

  if (NumElem < 1) begin : g_bad_grid
    initial $display("nbr_arb_datapath: empty grid");
  end
endmodule

// File: rtl/nbr_pixel_arbiter.sv
`timescale 1ns/1ps
module nbr_pixel_arbiter
  import nbr_arb_pkg::*;
#(
  parameter int GRID_COLS = 8,
  parameter int GRID_ROWS = 8,
  parameter int ADDR_W    = 9
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   reqValid,
  input  logic                                   reqBinary,
  input  logic [ADDR_W-1:0]                      planeBase,
  input  logic [TileBits-1:0]                    pixX,
  input  logic [TileBits-1:0]                    pixY,
  input  logic [OffBits-1:0]                     offX,
  input  logic [OffBits-1:0]                     offY,
  input  logic                                   bndWrite,
  input  logic [PixBits-1:0]                     bndValue,
  output logic                                   memRdEn,
  output logic [ADDR_W-1:0]                      memRdAddr,
  input  logic [PixBits*GRID_COLS*GRID_ROWS-1:0] memRdData,
  output logic                                   pixValid,
  output logic [PixBits*GRID_COLS*GRID_ROWS-1:0] pixData
);
  nbrStrobe_t strobe;

  nbr_arb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBinary(reqBinary),
    .planeBase(planeBase), .pixX(pixX), .pixY(pixY), .offX(offX), .offY(offY),
    .bndWrite(bndWrite), .bndValue(bndValue),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .strobe(strobe)
  );

  nbr_arb_datapath #(.GRID_COLS(GRID_COLS), .GRID_ROWS(GRID_ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memRdData(memRdData), .pixData(pixData)
  );

  assign pixValid = strobe.rdValid;
endmodule

// File: rtl/nbr_arb_checker.sv
`timescale 1ns/1ps
module nbr_arb_checker
  import nbr_arb_pkg::*;
#(
  parameter int GRID_COLS = 8,
  parameter int GRID_ROWS = 8,
  parameter int ADDR_W    = 9
) (
  input logic                                   clk,
  input logic                                   rstN,
  input logic                                   reqValid,
  input logic                                   reqBinary,
  input logic [ADDR_W-1:0]                      planeBase,
  input logic [TileBits-1:0]                    pixX,
  input logic [OffBits-1:0]                     offX,
  input logic                                   bndWrite,
  input logic [PixBits-1:0]                     bndValue,
  input logic [ADDR_W-1:0]                      memRdAddr,
  input logic                                   pixValid,
  input logic [PixBits*GRID_COLS*GRID_ROWS-1:0] pixData
);
  logic [ADDR_W-1:0]  addrDelta;
  logic [PixBits-1:0] bndModel;
  logic               westGrayQ;
  logic signed [TileBits+1:0] colSum;

  assign addrDelta = memRdAddr - planeBase;
  assign colSum = $signed({2'b00, pixX}) + $signed({offX[OffBits-1], offX});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bndModel  <= '0;
      westGrayQ <= 1'b0;
    end else begin
      if (bndWrite) bndModel <= bndValue;
      westGrayQ <= reqValid && !reqBinary && (colSum < 0);
    end
  end

  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> pixValid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !pixValid);

  p_gray_addr_in_plane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqBinary) |-> (addrDelta < ADDR_W'(TileSide * TileSide)));

  p_bin_addr_in_plane_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqBinary) |-> (addrDelta < ADDR_W'(TileSide)));

  // element 0 sits in column 0, so any westward grey read reaches off the grid
  p_west_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && westGrayQ) |-> (pixData[PixBits-1:0] == bndModel));
endmodule

bind nbr_pixel_arbiter nbr_arb_checker #(
  .GRID_COLS(GRID_COLS), .GRID_ROWS(GRID_ROWS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBinary(reqBinary),
  .planeBase(planeBase), .pixX(pixX), .offX(offX), .bndWrite(bndWrite),
  .bndValue(bndValue), .memRdAddr(memRdAddr), .pixValid(pixValid),
  .pixData(pixData)
);

// File: tb/test_nbr_pixel_arbiter.sv
`timescale 1ns/1ps
module test_nbr_pixel_arbiter;
  localparam int Cols = 3;
  localparam int Rows = 3;
  localparam int AW   = 9;
  localparam int NE   = Cols * Rows;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0, reqBinary = 1'b0;
  logic [AW-1:0]   planeBase = '0;
  logic [2:0]      pixX = '0, pixY = '0;
  logic [3:0]      offX = '0, offY = '0;
  logic            bndWrite = 1'b0;
  logic [7:0]      bndValue = '0;
  logic            memRdEn;
  logic [AW-1:0]   memRdAddr;
  logic [8*NE-1:0] memRdData = '0;
  logic            pixValid;
  logic [8*NE-1:0] pixData;

  int checks = 0, fails = 0;
  bit done = 0;
  int curBnd = 0;

  always #2.5 clk = ~clk;

  nbr_pixel_arbiter #(.GRID_COLS(Cols), .GRID_ROWS(Rows), .ADDR_W(AW)) i_nbr_pixel_arbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBinary(reqBinary),
    .planeBase(planeBase), .pixX(pixX), .pixY(pixY), .offX(offX), .offY(offY),
    .bndWrite(bndWrite), .bndValue(bndValue), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .pixValid(pixValid),
    .pixData(pixData)
  );

  function automatic int memByte(int e, int a);
    return (e * 37 + a * 11 + (a >> 3) + 5) & 255;
  endfunction

  always @(posedge clk)
    if (memRdEn)
      for (int e = 0; e < NE; e++) memRdData[e*8 +: 8] <= 8'(memByte(e, int'(memRdAddr)));

  function automatic int tileOf(int v);
    return (v < 0) ? -1 : ((v >= 8) ? 1 : 0);
  endfunction

  function automatic bit inGrid(int c, int r);
    return c >= 0 && c < Cols && r >= 0 && r < Rows;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives the request, checks the address, waits one
  // cycle and checks the results at the following negedge
  task automatic doReq(bit bin, int base, int px, int py, int ox, int oy);
    int tx, ty, sx, sy, lx, ly, addr, exp, act, col, tc, bp, sb;
    reqValid = 1'b1; reqBinary = bin; planeBase = AW'(base);
    pixX = 3'(px); pixY = 3'(py); offX = 4'(ox); offY = 4'(oy);
    tx = px + ox; ty = py + oy;
    sx = tileOf(tx); sy = tileOf(ty);
    lx = tx - 8 * sx; ly = ty - 8 * sy;
    addr = bin ? (base + ly) % (1 << AW) : (base + 8 * ly + lx) % (1 << AW);
    #1;
    check(memRdEn == 1'b1, "R2", int'(memRdEn), 1, "memRdEn");
    check(int'(memRdAddr) == addr, bin ? "R6" : "R3", int'(memRdAddr), addr, "address");
    @(negedge clk);
    check(pixValid == 1'b1, "R2", int'(pixValid), 1, "pixValid");
    for (int r = 0; r < Rows; r++)
      for (int c = 0; c < Cols; c++) begin
        act = int'(pixData[(r*Cols+c)*8 +: 8]);
        if (!bin) begin
          if (inGrid(c + sx, r + sy)) begin
            exp = memByte((r + sy) * Cols + c + sx, addr);
            check(act == exp, "R4", act, exp, "grey neighbour byte");
          end else begin
            exp = curBnd;
            check(act == exp, "R5", act, exp, "grey boundary byte");
          end
        end else begin
          exp = 0; sb = 0;
          for (int i = 0; i < 8; i++) begin
            col = ox + i; tc = tileOf(col); bp = col - 8 * tc;
            if (inGrid(c + tc, r + sy)) exp |= ((memByte((r + sy) * Cols + c + tc, addr) >> bp) & 1) << i;
            else begin exp |= ((curBnd >> bp) & 1) << i; sb = 1; end
          end
          check(act == exp, sb ? "R8" : "R7", act, exp, "binary window");
        end
      end
  endtask

  task automatic writeBnd(int v);
    @(negedge clk);
    bndWrite = 1'b1; bndValue = 8'(v);
    @(negedge clk);
    bndWrite = 1'b0;
    curBnd = v;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(pixValid == 1'b0, "R1", int'(pixValid), 0, "pixValid in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(pixValid == 1'b0, "R1", int'(pixValid), 0, "pixValid after reset");
    // R1: boundary byte is zero before any write (curBnd is 0)
    doReq(0, 0, 0, 0, -8, -8);
    doReq(1, 3, 0, 0, -5, 2);
    reqValid = 1'b0;
    @(negedge clk);
    check(pixValid == 1'b0, "R2", int'(pixValid), 0, "pixValid idle");

    // R9: load a boundary byte, then sweep every grey access
    writeBnd(8'hA5);
    base = 0;
    for (int py = 0; py < 8; py++)
      for (int px = 0; px < 8; px++)
        for (int oy = -8; oy < 8; oy++)
          for (int ox = -8; ox < 8; ox++) begin
            doReq(0, base, px, py, ox, oy);
            base = (base + 29) % (1 << AW);
          end
    reqValid = 1'b0;
    @(negedge clk);
    check(pixValid == 1'b0, "R2", int'(pixValid), 0, "pixValid after grey sweep");

    // R9: new value; bndValue then changes with bndWrite low and must be ignored
    writeBnd(8'h3C);
    bndValue = 8'hFF;
    base = 500;
    for (int py = 0; py < 8; py++)
      for (int oy = -8; oy < 8; oy++)
        for (int ox = -8; ox < 8; ox++)
          for (int px = 0; px < 8; px += 5) begin
            doReq(1, base, px, py, ox, oy);
            base = (base + 3) % (1 << AW);
          end
    reqValid = 1'b0;
    @(negedge clk);
    check(pixValid == 1'b0, "R2", int'(pixValid), 0, "pixValid after binary sweep");

    // R9: write in the same cycle as a request applies to that result
    @(negedge clk);
    bndWrite = 1'b1; bndValue = 8'h5A; curBnd = 8'h5A;
    doReq(0, 7, 0, 0, -8, 0);
    bndWrite = 1'b0;
    reqValid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule